// File: doc/BRIEF.md
# Polled Serial Console Register Block

This block puts a fixed-format UART on a 16-bit processor bus as a console with four word registers. Software finds the transmitter ready flag and the receiver done flag in bit 7 of two status registers. It moves characters through two data registers. Nothing has to be written before the console works. The line format is fixed at one start bit, 8 data bits sent LSB first, no parity and one stop bit. Bit timing comes from a baud tick input that pulses at `OVS` times the bit rate.

A host polls transmitter status until bit 7 is set, then writes a byte to the transmitter data register. It polls receiver status until bit 7 is set, then reads the receiver data register, and that read clears the flag. The block decodes an I/O-space select and a word address. The four registers sit at consecutive even addresses starting at a parameterized base, which defaults to octal 17777560.

Top module: `con_console`

## Requirements
- R1: A bus access hits only when `io_sel_i` is 1 and `addr_i[21:3]` equals the base address bits 21:3. On a hit, `addr_i[2:1]` selects the register: 0 is receiver status, 1 is receiver data, 2 is transmitter status and 3 is transmitter data. `addr_i[0]` is ignored. A read that misses returns 0, and a write that misses has no effect.
- R2: After reset, `txd_o` is 1, transmitter status reads 0x0080 and receiver status reads 0x0000.
- R3: Read data appears on `rdata_o` in the cycle after the clock edge that samples `rd_i`. In every other cycle `rdata_o` is 0.
- R4: Transmitter status returns the ready flag in bit 7. Receiver status returns the done flag in bit 7. All other status bits read 0.
- R5: A write to transmitter data while ready is 1 drives a frame on `txd_o` from the next cycle: a start bit of 0, then `wdata_i[7:0]` LSB first, then a stop bit of 1. Each bit lasts `OVS` baud ticks.
- R6: Ready reads 0 from the write edge onward. It returns to 1 at the edge of the 10*OVS-th baud tick after the write, which is the end of the stop bit.
- R7: A write to transmitter data while ready is 0 is ignored, and the frame in progress is unaffected.
- R8: After a valid frame with a stop bit of 1 arrives on `rxd_i`, receiver status bit 7 reads 1.
- R9: Reading receiver data returns the last received byte in bits 7:0 and 0 in bits 15:8, and it clears the done flag.
- R10: Writes to receiver status, receiver data and transmitter status change nothing.
- R11: A frame whose stop bit is 0 is discarded and does not set done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at OVS times the bit rate |
| io_sel_i | input | 1 | The access is to I/O space |
| addr_i | input | 22 | Byte address of the access |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| rxd_i | input | 1 | Serial receive line, idle high |
| txd_o | output | 1 | Serial transmit line, idle high |

## Verification
Read data is due one edge after the read strobe, and the ready flag falls and `txd_o` drops to the start bit at the same edge that takes the write. The bench drives inputs on falling edges and keeps a behavioural model that it updates at each rising edge from the sampled inputs. On every falling edge it compares `rdata_o` and `txd_o` with the model, which places every comparison exactly one register stage after its stimulus. A frame is 10*OVS baud ticks long, and the model counts ticks instead of cycles. The moment the receiver raises done inside the stop bit depends on synchronizer latency, so the bench reads receiver registers only after a frame and an idle gap have passed.

// File: rtl/con_pkg.sv
package con_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned FRAME_BITS = 10;

  typedef enum logic [1:0] {
    REG_RXST  = 2'd0,
    REG_RXDAT = 2'd1,
    REG_TXST  = 2'd2,
    REG_TXDAT = 2'd3
  } con_reg_e;
endpackage

// File: rtl/con_bus_dec.sv
module con_bus_dec
  import con_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 22'o17777560
) (
  input  logic              io_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              rd_hit_o,
  output logic              wr_hit_o,
  output con_reg_e          sel_o
);
  logic hit;
  assign hit      = io_sel_i && (addr_i[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);
  assign rd_hit_o = hit && rd_i;
  assign wr_hit_o = hit && wr_i;
  assign sel_o    = con_reg_e'(addr_i[2:1]);
endmodule

// File: rtl/con_uart_tx.sv
module con_uart_tx
  import con_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              ready_o,
  output logic              txd_o
);
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] TICK_LAST = CW'(OVS - 1);
  localparam logic [3:0]    BIT_LAST  = 4'(FRAME_BITS - 1);

  logic                  busy_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [CW-1:0]         tcnt_q;
  logic [3:0]            bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      tcnt_q <= '0;
      bcnt_q <= '0;
    end else if (!busy_q) begin
      if (ld_i) begin
        busy_q <= 1'b1;
        sh_q   <= {1'b1, data_i, 1'b0};
        tcnt_q <= '0;
        bcnt_q <= '0;
      end
    end else if (tick_i) begin
      if (tcnt_q == TICK_LAST) begin
        tcnt_q <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_BITS-1:1]};
        if (bcnt_q == BIT_LAST) busy_q <= 1'b0;
        else                    bcnt_q <= bcnt_q + 4'd1;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign ready_o = !busy_q;
  assign txd_o   = sh_q[0];

  assert_start_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !busy_q) |=> !txd_o);
  assert_idle_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> txd_o);
  assert_busy_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ld_i && !tick_i) |=> $stable(sh_q));
endmodule

// File: rtl/con_uart_rx.sv
module con_uart_rx
  import con_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              clr_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] TICK_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);
  localparam logic [3:0]    BIT_LAST  = 4'(FRAME_BITS - 1);

  typedef enum logic {RX_IDLE, RX_RUN} rx_st_e;

  rx_st_e            st_q;
  logic [1:0]        sync_q;
  logic              rxs;
  logic [3:0]        idx_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     lim;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] data_q;
  logic              done_q;

  assign rxs = sync_q[1];
  // first sample lands mid start bit, later ones a full bit apart
  assign lim = (idx_q == 4'd0) ? HALF_LAST : TICK_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      sync_q <= 2'b11;
      idx_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      if (clr_i) done_q <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (tick_i && !rxs) begin
          st_q  <= RX_RUN;
          cnt_q <= '0;
          idx_q <= '0;
        end
        RX_RUN: if (tick_i) begin
          if (cnt_q != lim) begin
            cnt_q <= cnt_q + 1'b1;
          end else begin
            cnt_q <= '0;
            idx_q <= idx_q + 4'd1;
            if (idx_q == 4'd0) begin
              if (rxs) st_q <= RX_IDLE;
            end else if (idx_q == BIT_LAST) begin
              st_q <= RX_IDLE;
              if (rxs) begin
                data_q <= sh_q;
                done_q <= 1'b1;
              end
            end else begin
              sh_q <= {rxs, sh_q[BYTE_W-1:1]};
            end
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;

  assert_done_needs_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(rxs));
  assert_done_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && st_q == RX_IDLE) |=> !done_q);
endmodule

// File: rtl/con_console.sv
module con_console
  import con_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 22'o17777560,
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              io_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rxd_i,
  output logic              txd_o
);
  logic              rd_hit, wr_hit;
  con_reg_e          sel;
  logic              tx_ready, rx_done;
  logic [BYTE_W-1:0] rx_data;
  logic [DATA_W-1:0] rdata_q;

  con_bus_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .io_sel_i (io_sel_i),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .rd_hit_o (rd_hit),
    .wr_hit_o (wr_hit),
    .sel_o    (sel)
  );

  con_uart_tx #(.OVS(OVS)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .ld_i    (wr_hit && sel == REG_TXDAT),
    .data_i  (wdata_i[BYTE_W-1:0]),
    .ready_o (tx_ready),
    .txd_o   (txd_o)
  );

  con_uart_rx #(.OVS(OVS)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (baud_tick_i),
    .rxd_i  (rxd_i),
    .clr_i  (rd_hit && sel == REG_RXDAT),
    .done_o (rx_done),
    .data_o (rx_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (rd_hit) begin
        unique case (sel)
          REG_RXST:  rdata_q[FLAG_BIT] <= rx_done;
          REG_RXDAT: rdata_q[BYTE_W-1:0] <= rx_data;
          REG_TXST:  rdata_q[FLAG_BIT] <= tx_ready;
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;

  assert_rdata_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> (rdata_o == '0));
  assert_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:BYTE_W] == '0);
  assert_miss_no_tx_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_sel_i && tx_ready && !wr_hit) |=> tx_ready);
endmodule

// File: tb/con_console_tb_top.sv
module con_console_tb_top;
  localparam int unsigned OVS = 8;
  localparam logic [21:0] BASE = 22'o17777560;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        baud_tick_i = 1'b0;
  logic        io_sel_i = 1'b0;
  logic [21:0] addr_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        rxd_i = 1'b1;
  logic        txd_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  bit       m_busy = 0;
  int       m_ticks = 0;
  bit [9:0] m_frame = '1;
  bit       m_rx_done = 0;
  bit [7:0] m_rx_data = '0;
  bit [15:0] exp_rdata = '0;
  bit       exp_txd = 1;

  con_console #(.OVS(OVS)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .baud_tick_i(baud_tick_i),
    .io_sel_i(io_sel_i), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rxd_i(rxd_i), .txd_o(txd_o)
  );

  always #5 clk_i = ~clk_i;

  always @(negedge clk_i) baud_tick_i <= ~baud_tick_i;

  always @(posedge clk_i) begin
    bit hit;
    int r;
    bit pre_busy;
    if (rst_ni) begin
      hit = io_sel_i && (addr_i[21:3] == BASE[21:3]);
      r = int'(addr_i[2:1]);
      pre_busy = m_busy;
      exp_rdata = '0;
      if (rd_i && hit) begin
        if (r == 0) exp_rdata = {8'h00, m_rx_done, 7'h00};
        if (r == 1) exp_rdata = {8'h00, m_rx_data};
        if (r == 2) exp_rdata = {8'h00, !pre_busy, 7'h00};
        if (r == 1) m_rx_done = 0;
      end
      if (pre_busy && baud_tick_i) begin
        m_ticks++;
        if (m_ticks == 10 * OVS) m_busy = 0;
      end
      if (!pre_busy && wr_i && hit && r == 3) begin
        m_busy = 1;
        m_ticks = 0;
        m_frame = {1'b1, wdata_i[7:0], 1'b0};
      end
      exp_txd = m_busy ? m_frame[m_ticks / OVS] : 1'b1;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      checks++;
      if (txd_o !== exp_txd) begin
        errors++;
        $display("FAIL R5 txd_o cycle %0d actual %b expected %b", cyc, txd_o, exp_txd);
      end
      checks++;
      if (rdata_o !== exp_rdata) begin
        errors++;
        $display("FAIL R3 rdata_o cycle %0d actual %h expected %h", cyc, rdata_o, exp_rdata);
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected below 100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic bus_wr(input int r, input logic [15:0] d, input bit sel = 1);
    @(negedge clk_i);
    io_sel_i = sel; addr_i = BASE + 22'(2 * r); wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; io_sel_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [21:0] a, input bit sel, input logic [15:0] exp,
                        input string tag);
    @(negedge clk_i);
    io_sel_i = sel; addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0; io_sel_i = 1'b0;
    checks++;
    if (rdata_o !== exp) begin
      errors++;
      $display("FAIL %s read %o actual %h expected %h", tag, a, rdata_o, exp);
    end
  endtask

  task automatic chk_txd(input logic exp, input string tag);
    @(negedge clk_i);
    checks++;
    if (txd_o !== exp) begin
      errors++;
      $display("FAIL %s txd_o actual %b expected %b", tag, txd_o, exp);
    end
  endtask

  task automatic rx_send(input logic [7:0] b, input bit stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxd_i = f[i];
      repeat (2 * OVS) @(negedge clk_i);
    end
    rxd_i = 1'b1;
    repeat (3 * OVS) @(negedge clk_i);
    if (stop) begin
      m_rx_data = b;
      m_rx_done = 1;
    end
  endtask

  task automatic wait_tx_done();
    repeat (2 * 10 * OVS + 8) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R2 reset state
    chk_txd(1'b1, "R2");
    rd_chk(BASE + 22'd0, 1, 16'h0000, "R2");
    rd_chk(BASE + 22'd4, 1, 16'h0080, "R2 R4");

    // R5 R6 transmit a byte, ready drops then returns
    bus_wr(3, 16'hFF42);
    rd_chk(BASE + 22'd4, 1, 16'h0000, "R6");
    wait_tx_done();
    rd_chk(BASE + 22'd4, 1, 16'h0080, "R6");

    // R7 write while busy ignored; model compares txd every clock
    bus_wr(3, 16'h00A5);
    repeat (5) @(negedge clk_i);
    bus_wr(3, 16'h003C);
    wait_tx_done();
    rd_chk(BASE + 22'd4, 1, 16'h0080, "R7");

    // R1 decode misses
    bus_wr(3, 16'h0055, 0);
    rd_chk(BASE + 22'd4, 1, 16'h0080, "R1");
    chk_txd(1'b1, "R1");
    rd_chk(BASE + 22'd4, 0, 16'h0000, "R1");
    rd_chk(BASE + 22'd12, 1, 16'h0000, "R1");
    rd_chk(BASE + 22'd5, 1, 16'h0080, "R1");

    // R8 R9 receive a byte
    rx_send(8'h5A, 1);
    rd_chk(BASE + 22'd0, 1, 16'h0080, "R8");
    rd_chk(BASE + 22'd2, 1, 16'h005A, "R9");
    rd_chk(BASE + 22'd0, 1, 16'h0000, "R9");

    // R10 writes to read-only registers change nothing
    rx_send(8'hC3, 1);
    bus_wr(0, 16'h0000);
    bus_wr(1, 16'h1234);
    bus_wr(2, 16'h0000);
    rd_chk(BASE + 22'd0, 1, 16'h0080, "R10");
    rd_chk(BASE + 22'd4, 1, 16'h0080, "R10");
    chk_txd(1'b1, "R10");
    rd_chk(BASE + 22'd2, 1, 16'h00C3, "R10 R9");

    // R11 bad stop bit discarded
    rx_send(8'h0F, 0);
    rx_send(8'hFF, 1);
    m_rx_done = 0;
    rd_chk(BASE + 22'd2, 1, 16'h00FF, "R8");
    rx_send(8'h81, 0);
    rd_chk(BASE + 22'd0, 1, 16'h0000, "R11");

    // transmit and receive together
    bus_wr(3, 16'h0081);
    rx_send(8'h3E, 1);
    wait_tx_done();
    rd_chk(BASE + 22'd0, 1, 16'h0080, "R8");
    rd_chk(BASE + 22'd2, 1, 16'h003E, "R9");
    rd_chk(BASE + 22'd4, 1, 16'h0080, "R6");

    repeat (4) @(negedge clk_i);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule